// File: doc/BRIEF.md
# Tiled View Address Generator

This block maps a pixel coordinate into a 32-bit address inside a tiled address space that can be read in any of eight rotated or mirrored views. A requester presents a pixel-format code, a 3-bit view code and an X/Y coordinate with a valid strobe. One clock later the block returns the composed address, a flag that marks the coordinate as out of range, and the line stride that a scan in that view must step by.

The path range-checks the coordinate against the format's usable width and height. It then mirrors each axis on request and swaps the axes for the quarter-turn views. It packs the coordinate into a linear offset, shifts the offset left by the format's alignment, and writes the format and view codes into the top address bits. The container size and the page-mode shift amounts are parameters.

Top module: `tiled_view_addr`

## Requirements
- R1: A result appears exactly one cycle after a cycle with `in_valid` high, with `out_valid` high in that cycle. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R2: After a synchronous active-low reset, `out_valid`, `addr_o`, `invalid_o` and `stride_o` are all zero.
- R3: With X width `xb = CW_BITS - xsh` and Y width `yb = CH_BITS - ysh`, a coordinate with `x > 2^xb - 1` or `y > 2^yb - 1` sets `invalid_o`, and `addr_o` is then 0.
- R4: For an in-range coordinate, `addr_o[28:27]` equals the format code and `addr_o[31:29]` equals the view code.
- R5: Format codes and their (xsh, ysh) shifts are: 0 = 8-bit (0,0), 1 = 16-bit (0,1), 2 = 32-bit (1,1), 3 = page mode (PAGE_XSH, PAGE_YSH), with a default of (6,6).
- R6: View bit 0 replaces X by `x XOR (2^xb - 1)`. View bit 1 replaces Y by `y XOR (2^yb - 1)`. Both are applied after the range check.
- R7: View bit 2 selects the axis swap. The linear offset is `(x << yb) + y` when bit 2 is set and `(y << xb) + x` when it is clear.
- R8: The linear offset is shifted left by `xsh + ysh` and occupies `addr_o[26:0]`.
- R9: `stride_o` is `1 << (CH_BITS + xsh)` when view bit 2 is set and `1 << (CW_BITS + ysh)` otherwise. This holds for in-range and out-of-range coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fmt_i | input | 2 | Pixel-format code |
| view_i | input | 3 | View code: bit0 X mirror, bit1 Y mirror, bit2 axis swap |
| x_i | input | CW_BITS | Pixel X coordinate |
| y_i | input | CH_BITS | Pixel Y coordinate |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| addr_o | output | CW_BITS+CH_BITS+5 | Composed tiled address |
| invalid_o | output | 1 | Coordinate was out of range |
| stride_o | output | CW_BITS+CH_BITS+5 | Line stride for the format and view |

## Verification
The datapath holds no state between requests, so any fault shows up at the ports in the first result after the stimulus that triggers it. A wrong shift or mask moves the coordinate bits to the wrong place, or flips the out-of-range flag at the width boundaries of one format only. For this reason each format is checked at its own largest legal coordinate and one step past it. A misplaced swap or mirror bit shows only in the views that use it, so all eight view codes are exercised against a model that is independent of the design.

// File: rtl/tva_pkg.sv
// Package: shared types for the tiled view address generator.
// Assumes format codes are fixed by the address encoding seen downstream.
package tva_pkg;
    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } tva_fmt_e;
endpackage

// File: rtl/tva_geom.sv
// Module: tva_geom
// Derives the per-format X/Y shift amounts and coordinate masks.
// Assumes PAGE_XSH < CW_BITS and PAGE_YSH < CH_BITS.
module tva_geom
    import tva_pkg::*;
#(
    parameter int CW_BITS  = 14,
    parameter int CH_BITS  = 13,
    parameter int PAGE_XSH = 6,
    parameter int PAGE_YSH = 6,
    parameter int SHA_W    = $clog2(CW_BITS + CH_BITS + 1)
) (
    input  tva_fmt_e           fmt,
    output logic [SHA_W-1:0]   xsh,
    output logic [SHA_W-1:0]   ysh,
    output logic [CW_BITS-1:0] xmask,
    output logic [CH_BITS-1:0] ymask
);
    // Select the shift pair for the format.
    always_comb begin
        unique case (fmt)
            FMT_B8:   begin xsh = '0;              ysh = '0;              end
            FMT_B16:  begin xsh = '0;              ysh = SHA_W'(1);       end
            FMT_B32:  begin xsh = SHA_W'(1);       ysh = SHA_W'(1);       end
            default:  begin xsh = SHA_W'(PAGE_XSH); ysh = SHA_W'(PAGE_YSH); end
        endcase
    end

    // The largest legal coordinate on each axis.
    always_comb begin
        xmask = {CW_BITS{1'b1}} >> xsh;
        ymask = {CH_BITS{1'b1}} >> ysh;
    end
endmodule

// File: rtl/tva_orient.sv
// Module: tva_orient
// Range-checks a coordinate against the format masks and applies mirroring.
// Assumes the masks come from tva_geom for the same format.
module tva_orient #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13
) (
    input  logic [CW_BITS-1:0] x_in,
    input  logic [CH_BITS-1:0] y_in,
    input  logic [CW_BITS-1:0] xmask,
    input  logic [CH_BITS-1:0] ymask,
    input  logic [1:0]         mirror,
    output logic               bad,
    output logic [CW_BITS-1:0] x_out,
    output logic [CH_BITS-1:0] y_out
);
    // Flag coordinates beyond the usable area.
    always_comb bad = (x_in > xmask) || (y_in > ymask);

    // Reflect each axis across its full mask when requested.
    always_comb begin
        x_out = mirror[0] ? (x_in ^ xmask) : x_in;
        y_out = mirror[1] ? (y_in ^ ymask) : y_in;
    end
endmodule

// File: rtl/tva_compose.sv
// Module: tva_compose
// Packs the oriented coordinate into an aligned linear offset and computes the stride.
// Assumes coordinates are already within their masks, so the offset fits OFF_W bits.
module tva_compose #(
    parameter int CW_BITS = 14,
    parameter int CH_BITS = 13,
    parameter int OFF_W   = CW_BITS + CH_BITS,
    parameter int SHA_W   = $clog2(CW_BITS + CH_BITS + 1),
    parameter int ADDR_W  = CW_BITS + CH_BITS + 5
) (
    input  logic [CW_BITS-1:0] xo,
    input  logic [CH_BITS-1:0] yo,
    input  logic               swap,
    input  logic [SHA_W-1:0]   xsh,
    input  logic [SHA_W-1:0]   ysh,
    output logic [OFF_W-1:0]   offset,
    output logic [ADDR_W-1:0]  stride
);
    logic [OFF_W-1:0] xw, yw, lin;
    logic [SHA_W-1:0] xbits, ybits;

    // Widen the coordinates and derive the axis widths.
    always_comb begin
        xw    = OFF_W'(xo);
        yw    = OFF_W'(yo);
        xbits = SHA_W'(CW_BITS) - xsh;
        ybits = SHA_W'(CH_BITS) - ysh;
    end

    // Row-major packing, with the axes exchanged on swap, then alignment.
    always_comb begin
        lin    = swap ? ((xw << ybits) + yw) : ((yw << xbits) + xw);
        offset = lin << (xsh + ysh);
    end

    // Line stride follows the axis that is now the row.
    always_comb begin
        stride = swap ? (ADDR_W'(1) << (SHA_W'(CH_BITS) + xsh))
                      : (ADDR_W'(1) << (SHA_W'(CW_BITS) + ysh));
    end
endmodule

// File: rtl/tiled_view_addr.sv
// Module: tiled_view_addr (top)
// Converts format, view and X/Y into a tiled view address with one cycle of latency.
// Assumes the address is exactly 5 field bits above a CW_BITS+CH_BITS offset.
module tiled_view_addr
    import tva_pkg::*;
#(
    parameter int CW_BITS  = 14,
    parameter int CH_BITS  = 13,
    parameter int PAGE_XSH = 6,
    parameter int PAGE_YSH = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 fmt_i,
    input  logic [2:0]                 view_i,
    input  logic [CW_BITS-1:0]         x_i,
    input  logic [CH_BITS-1:0]         y_i,
    output logic                       out_valid,
    output logic [CW_BITS+CH_BITS+4:0] addr_o,
    output logic                       invalid_o,
    output logic [CW_BITS+CH_BITS+4:0] stride_o
);
    localparam int OFF_W  = CW_BITS + CH_BITS;
    localparam int ADDR_W = OFF_W + 5;
    localparam int SHA_W  = $clog2(OFF_W + 1);

    tva_fmt_e           fmt_e;
    logic [SHA_W-1:0]   xsh, ysh;
    logic [CW_BITS-1:0] xmask, xo;
    logic [CH_BITS-1:0] ymask, yo;
    logic               bad;
    logic [OFF_W-1:0]   offset;
    logic [ADDR_W-1:0]  addr_c, stride_c;

    // Interpret the raw format code.
    always_comb fmt_e = tva_fmt_e'(fmt_i);

    tva_geom #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
        .PAGE_XSH(PAGE_XSH), .PAGE_YSH(PAGE_YSH), .SHA_W(SHA_W)
    ) u_geom (
        .fmt(fmt_e), .xsh(xsh), .ysh(ysh), .xmask(xmask), .ymask(ymask)
    );

    tva_orient #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) u_orient (
        .x_in(x_i), .y_in(y_i), .xmask(xmask), .ymask(ymask),
        .mirror(view_i[1:0]), .bad(bad), .x_out(xo), .y_out(yo)
    );

    tva_compose #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .OFF_W(OFF_W),
        .SHA_W(SHA_W), .ADDR_W(ADDR_W)
    ) u_compose (
        .xo(xo), .yo(yo), .swap(view_i[2]), .xsh(xsh), .ysh(ysh),
        .offset(offset), .stride(stride_c)
    );

    // Insert view and format fields, or force zero for a rejected coordinate.
    always_comb addr_c = bad ? '0 : {view_i, fmt_i, offset};

    // Output register: capture a result on each request, strobe it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            addr_o    <= '0;
            invalid_o <= 1'b0;
            stride_o  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                addr_o    <= addr_c;
                invalid_o <= bad;
                stride_o  <= stride_c;
            end
        end
    end

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid_o) |-> (addr_o == '0)); // R3
    AST_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (invalid_o ||
            (addr_o[ADDR_W-1 -: 5] == {$past(view_i), $past(fmt_i)}))); // R4
    AST_STRIDE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(stride_o) == 1)); // R9
endmodule

// File: tb/tb_tiled_view_addr.sv
`timescale 1ns/1ps
module tb_tiled_view_addr;
    localparam int CW = 14;
    localparam int CH = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  fmt_i = '0;
    logic [2:0]  view_i = '0;
    logic [CW-1:0] x_i = '0;
    logic [CH-1:0] y_i = '0;
    logic        out_valid;
    logic [31:0] addr_o;
    logic        invalid_o;
    logic [31:0] stride_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tiled_view_addr dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_i(fmt_i),
        .view_i(view_i), .x_i(x_i), .y_i(y_i), .out_valid(out_valid),
        .addr_o(addr_o), .invalid_o(invalid_o), .stride_o(stride_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Reference model written from the requirement text.
    task automatic model(input int f, input int v, input int x, input int y,
                         output logic [31:0] a, output logic bad, output logic [31:0] st);
        int xs, ys, xb, yb, xm, ym;
        longint off;
        case (f)
            0: begin xs = 0; ys = 0; end
            1: begin xs = 0; ys = 1; end
            2: begin xs = 1; ys = 1; end
            default: begin xs = 6; ys = 6; end
        endcase
        xb = CW - xs; yb = CH - ys;
        xm = (1 << xb) - 1; ym = (1 << yb) - 1;
        bad = (x > xm) || (y > ym);
        if (v[0]) x = x ^ xm;
        if (v[1]) y = y ^ ym;
        off = v[2] ? ((longint'(x) << yb) + y) : ((longint'(y) << xb) + x);
        off = off << (xs + ys);
        a = bad ? 32'h0 : ((32'(v) << 29) | (32'(f) << 27) | 32'(off & 64'h7FF_FFFF));
        st = v[2] ? (32'h1 << (CH + xs)) : (32'h1 << (CW + ys));
    endtask

    // One request, sampled at the negedge after the capturing posedge.
    task automatic run(input string req, input int f, input int v, input int x, input int y);
        logic [31:0] ea, es;
        logic eb;
        model(f, v, x, y, ea, eb, es);
        @(negedge clk);
        fmt_i = 2'(f); view_i = 3'(v); x_i = CW'(x); y_i = CH'(y); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 out_valid", {31'b0, out_valid}, 32'h1);
        chk({req, " addr"}, addr_o, ea);
        chk("R3 invalid", {31'b0, invalid_o}, {31'b0, eb});
        chk("R9 stride", stride_o, es);
    endtask

    task automatic t_reset();
        chk("R2 out_valid", {31'b0, out_valid}, 32'h0);
        chk("R2 addr", addr_o, 32'h0);
        chk("R2 invalid", {31'b0, invalid_o}, 32'h0);
        chk("R2 stride", stride_o, 32'h0);
    endtask

    task automatic t_formats();   // R5 R8
        run("R5", 0, 0, 5, 3);
        run("R5", 1, 0, 100, 200);
        run("R5", 2, 0, 4000, 1234);
        run("R8", 3, 0, 200, 90);
        run("R8", 2, 0, 8191, 4095);
    endtask

    task automatic t_mirror();    // R6
        for (int v = 1; v < 4; v++) begin
            run("R6", 0, v, 7, 11);
            run("R6", 2, v, 300, 17);
            run("R6", 3, v, 0, 0);
        end
    endtask

    task automatic t_swap();      // R7
        for (int v = 4; v < 8; v++) begin
            run("R7", 0, v, 9, 21);
            run("R7", 1, v, 16383, 1);
            run("R7", 3, v, 255, 127);
        end
    endtask

    task automatic t_fields();    // R4
        for (int f = 0; f < 4; f++)
            for (int v = 0; v < 8; v++)
                run("R4", f, v, 1, 1);
    endtask

    task automatic t_range();     // R3
        run("R3", 0, 0, 16383, 8191);
        run("R3", 1, 3, 0, 4096);
        run("R3", 1, 0, 0, 4095);
        run("R3", 2, 0, 8192, 0);
        run("R3", 2, 5, 8191, 4096);
        run("R3", 3, 6, 256, 0);
        run("R3", 3, 0, 255, 128);
    endtask

    task automatic t_idle();      // R1
        @(negedge clk);
        chk("R1 idle", {31'b0, out_valid}, 32'h0);
        @(negedge clk);
        chk("R1 idle", {31'b0, out_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_mirror();
        t_swap();
        t_fields();
        t_range();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule